// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Line Ownership

This block controls up to 32 general-purpose pins through a 32-bit register port. It holds two complete register banks. Each bank has output, direction, interrupt polarity, interrupt flag and interrupt mask registers, plus read-only views of the inputs. The primary bank can always be reached. The secondary bank, together with a per-line owner register and a secondary drive-enable register, can be reached only while an external `permit` input is high.

Each line belongs to exactly one bank, chosen by its owner bit. The owning bank drives the pad output and output-enable for that line and records interrupt flags for it. The other bank cannot touch that line.

Pad inputs are synchronised before any use. Interrupts are level-sensitive with a per-line polarity. Flags are cleared by writing one to them. Each bank raises its own interrupt output whenever one of its unmasked flags is set. Bus words are big-endian: the register value is the byte-reversed bus word.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset, every output, direction, mask, flag, drive-enable and owner bit is 0. All lines therefore belong to the secondary bank, `pad_out` and `pad_oe` are 0, and both interrupt outputs are low.
- R2: Register bit i maps to line i. The register value equals the bus word with its four bytes reversed, so bus word 0x01000000 addresses line 0 and bus word 0x00000001 addresses line 24.
- R3: Primary registers at word offsets 0x00–0x18 can always be accessed. The secondary bank (0x20–0x38), the drive-enable register (0x1C) and the owner register (0x3C) can be accessed only while `permit` is 1. Otherwise writes are ignored and reads return 0.
- R4: An owner bit of 1 gives the line to the primary bank. Its pad value is then the primary output bit, and its enable is the primary direction bit. An owner bit of 0 gives the line to the secondary bank. Its enable is then the secondary direction bit ANDed with the drive-enable bit.
- R5: In the bank that does not own a line, output and direction writes to that line are ignored, and reads of that line return 0.
- R6: Pad inputs pass through two flops. The input register (0x08/0x28) shows a change after the second rising edge. The mirror register (0x18/0x38) returns the input ANDed with the lines owned by that bank.
- R7: A bank sets a line's flag only while it owns the line and the synchronised input equals the polarity bit. Polarity 1 flags on high and polarity 0 flags on low. The flag sets on the edge after the synchronised value appears.
- R8: Writing 1 to a flag bit clears it and writing 0 has no effect. If the flag condition still holds in the clearing cycle, the flag stays set.
- R9: `irq_prim` and `irq_sec` are high exactly while their bank's flag AND mask is nonzero.
- R10: An address with bits [1:0] nonzero or bits above [5] nonzero is unmapped: writes are ignored and reads return 0. Writes to the input and mirror registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| permit | input | 1 | Grants access to the secondary bank, drive-enable and owner registers |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | 32 | Write data, big-endian |
| bus_rdata | output | 32 | Read data, big-endian, combinational |
| pad_in | input | NLINES (32) | Pad input levels |
| pad_out | output | NLINES (32) | Pad output values |
| pad_oe | output | NLINES (32) | Pad output enables |
| irq_prim | output | 1 | Primary bank interrupt |
| irq_sec | output | 1 | Secondary bank interrupt |

## Verification
The bench targets the following corner cases:
- **Split ownership.** It writes all-ones to both output registers and expects each bank to read back only its own half. A design that ignored ownership would read all-ones twice. It then moves one line across banks and expects the pad to show the new owner's never-written zero rather than a stale value.
- **Withdrawn permit.** It writes the owner register and reads the secondary bank. A leaking gate would show changed ownership or nonzero data.
- **Input timing.** It samples the input and flag registers one and two edges after a pad change. An extra or missing synchroniser stage would show up one cycle early or late.
- **Clear against a live condition.** It clears a flag whose condition is still true. A clear that took priority would drop a level interrupt that is still pending.
- **Lane order.** Raw bus words probe the byte order. A design that skipped the byte swap would mask the wrong line.

// File: rtl/gpio_db_pkg.sv
// Package: shared constants and helpers for the dual-bank GPIO controller.
// Assumes a 32-bit register word and word-aligned byte addresses.
package gpio_db_pkg;

    localparam int REG_W = 32;

    // Field slot inside a bank (word index bits [2:0]); bit [3] picks the bank
    localparam logic [2:0] FLD_OUT  = 3'd0;
    localparam logic [2:0] FLD_DIR  = 3'd1;
    localparam logic [2:0] FLD_IN   = 3'd2;
    localparam logic [2:0] FLD_LVL  = 3'd3;
    localparam logic [2:0] FLD_FLAG = 3'd4;
    localparam logic [2:0] FLD_MASK = 3'd5;
    localparam logic [2:0] FLD_MIR  = 3'd6;
    localparam logic [2:0] FLD_XTRA = 3'd7;   // drive-enable in bank 0 half, owner in bank 1 half

    // Reverse the byte order of a bus word
    function automatic logic [REG_W-1:0] byte_rev(input logic [REG_W-1:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/gpio_db_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_db_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the input one stage further into the clock domain
        always_ff @(posedge clk) begin
            if (!rst_n)      stage[s] <= '0;
            else if (s == 0) stage[s] <= d;
            else             stage[s] <= stage[(s > 0) ? s - 1 : 0];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_db_bank.sv
// Module: one GPIO register bank. Holds output, direction, polarity, flag and
// mask for all lines, but only acts on the lines marked in `owned`.
// Assumes line_in is already synchronised and that at most one write strobe
// is high per cycle.
module gpio_db_bank #(
    parameter int NL = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] owned,
    input  logic [NL-1:0] en_mask,
    input  logic [NL-1:0] line_in,
    input  logic [NL-1:0] wdata,
    input  logic          wr_out,
    input  logic          wr_dir,
    input  logic          wr_lvl,
    input  logic          wr_flag,
    input  logic          wr_mask,
    output logic [NL-1:0] rd_out,
    output logic [NL-1:0] rd_dir,
    output logic [NL-1:0] lvl_q,
    output logic [NL-1:0] flag_q,
    output logic [NL-1:0] mask_q,
    output logic [NL-1:0] drv_out,
    output logic [NL-1:0] drv_oe,
    output logic          irq
);
    logic [NL-1:0] out_q, dir_q;
    logic [NL-1:0] hit, clr;

    // Lines whose synchronised level matches their programmed polarity
    assign hit = owned & ~(line_in ^ lvl_q);
    assign clr = wr_flag ? wdata : '0;

    // Output and direction: only owned bits take a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else begin
            if (wr_out) out_q <= (out_q & ~owned) | (wdata & owned);
            if (wr_dir) dir_q <= (dir_q & ~owned) | (wdata & owned);
        end
    end

    // Polarity and mask: plain read/write registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_lvl)  lvl_q  <= wdata;
            if (wr_mask) mask_q <= wdata;
        end
    end

    // Flags: write-one-to-clear, a live condition wins over the clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr) | hit;
    end

    assign rd_out  = out_q & owned;
    assign rd_dir  = dir_q & owned;
    assign drv_out = rd_out;
    assign drv_oe  = rd_dir & en_mask;
    assign irq     = |(flag_q & mask_q);
endmodule

// File: rtl/gpio_dual_bank.sv
// Module: top of the dual-bank GPIO controller. Decodes the register port,
// gates secondary access with `permit`, steers each line to its owning bank
// and merges the pad drive of both banks.
// Assumes NLINES <= 32, AW >= 7 and a single-cycle register port with
// combinational read data.
module gpio_dual_bank
    import gpio_db_pkg::*;
#(
    parameter int NLINES      = 32,
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              permit,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic              irq_prim,
    output logic              irq_sec
);
    localparam int NBANK = 2;

    logic [NLINES-1:0] sync_in;
    logic [NLINES-1:0] own_q, en_q;
    logic [REG_W-1:0]  wd_le, rd_le;
    logic [NLINES-1:0] wline;
    logic [3:0]        word;
    logic [2:0]        fld;
    logic              in_range, gated, reach, wr_ok, rd_ok;

    logic [NLINES-1:0] owned_v [NBANK];
    logic [NLINES-1:0] enm_v   [NBANK];
    logic [NLINES-1:0] b_rdout [NBANK];
    logic [NLINES-1:0] b_rddir [NBANK];
    logic [NLINES-1:0] b_lvl   [NBANK];
    logic [NLINES-1:0] b_flag  [NBANK];
    logic [NLINES-1:0] b_mask  [NBANK];
    logic [NLINES-1:0] b_dout  [NBANK];
    logic [NLINES-1:0] b_doe   [NBANK];
    logic              b_irq   [NBANK];

    // Zero-extend a line vector to a register word
    function automatic logic [REG_W-1:0] widen(input logic [NLINES-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        r[NLINES-1:0] = v;
        return r;
    endfunction

    // Address decode and access gating
    assign word     = bus_addr[5:2];
    assign fld      = word[2:0];
    assign in_range = (bus_addr[AW-1:6] == '0) && (bus_addr[1:0] == 2'b00);
    assign gated    = word[3] || (fld == FLD_XTRA);
    assign reach    = in_range && (!gated || permit);
    assign wr_ok    = bus_sel && bus_wr && reach;
    assign rd_ok    = bus_sel && !bus_wr && reach;
    assign wd_le    = byte_rev(bus_wdata);
    assign wline    = wd_le[NLINES-1:0];

    gpio_db_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_in)
    );

    // Owner and secondary drive-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= '0;
            en_q  <= '0;
        end else if (wr_ok && fld == FLD_XTRA) begin
            if (word[3]) own_q <= wline;
            else         en_q  <= wline;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic wr_b;
        assign owned_v[b] = (b == 0) ? own_q : ~own_q;
        assign enm_v[b]   = (b == 0) ? '1 : en_q;
        assign wr_b       = wr_ok && (word[3] == 1'(b));

        gpio_db_bank #(.NL(NLINES)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .owned   (owned_v[b]),
            .en_mask (enm_v[b]),
            .line_in (sync_in),
            .wdata   (wline),
            .wr_out  (wr_b && fld == FLD_OUT),
            .wr_dir  (wr_b && fld == FLD_DIR),
            .wr_lvl  (wr_b && fld == FLD_LVL),
            .wr_flag (wr_b && fld == FLD_FLAG),
            .wr_mask (wr_b && fld == FLD_MASK),
            .rd_out  (b_rdout[b]),
            .rd_dir  (b_rddir[b]),
            .lvl_q   (b_lvl[b]),
            .flag_q  (b_flag[b]),
            .mask_q  (b_mask[b]),
            .drv_out (b_dout[b]),
            .drv_oe  (b_doe[b]),
            .irq     (b_irq[b])
        );
    end

    // Read multiplexer over both banks and the shared registers
    always_comb begin
        rd_le = '0;
        if (rd_ok) begin
            unique case (fld)
                FLD_OUT:  rd_le = widen(b_rdout[word[3]]);
                FLD_DIR:  rd_le = widen(b_rddir[word[3]]);
                FLD_IN:   rd_le = widen(sync_in);
                FLD_LVL:  rd_le = widen(b_lvl[word[3]]);
                FLD_FLAG: rd_le = widen(b_flag[word[3]]);
                FLD_MASK: rd_le = widen(b_mask[word[3]]);
                FLD_MIR:  rd_le = widen(sync_in & owned_v[word[3]]);
                FLD_XTRA: rd_le = word[3] ? widen(own_q) : widen(en_q);
                default:  rd_le = '0;
            endcase
        end
    end

    assign bus_rdata = byte_rev(rd_le);
    assign pad_out   = b_dout[0] | b_dout[1];
    assign pad_oe    = b_doe[0] | b_doe[1];
    assign irq_prim  = b_irq[0];
    assign irq_sec   = b_irq[1];
endmodule

// File: rtl/gpio_dual_bank_chk.sv
// Module: property checker for gpio_dual_bank, attached with bind.
// Assumes the default address width of 8 bits.
module gpio_dual_bank_chk #(
    parameter int NLINES = 32,
    parameter int AW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              permit,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NLINES-1:0] pad_oe,
    input logic              irq_prim,
    input logic              irq_sec,
    input logic [NLINES-1:0] own_q
);
    logic sec_addr;
    assign sec_addr = (bus_addr >= AW'(8'h1C)) && (bus_addr <= AW'(8'h3C));

    // R1: state right after reset release
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (own_q == '0) && (pad_oe == '0) && !irq_prim && !irq_sec);

    // R3: owner cannot change without permit
    a_r3_owner_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !permit && bus_addr == AW'(8'h3C)) |=> $stable(own_q));

    // R3: secondary direction writes without permit leave pad enables alone
    a_r3_oe_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !permit && (bus_addr == AW'(8'h24) || bus_addr == AW'(8'h1C)))
        |=> $stable(pad_oe));

    // R3: reads of gated registers return zero without permit
    a_r3_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !permit && sec_addr) |-> (bus_rdata == '0));

    // R9: clearing the primary mask silences the primary interrupt
    a_r9_mask_clear_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == AW'(8'h14) && bus_wdata == '0) |=> !irq_prim);
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.NLINES(NLINES), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .permit    (permit),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .irq_prim  (irq_prim),
    .irq_sec   (irq_sec),
    .own_q     (own_q)
);

// File: tb/gpio_dual_bank_test.sv
// Bench: table walk of register accesses, then directed tests for timing,
// interrupts, lane order and reset.
module gpio_dual_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        permit = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_prim, irq_sec;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    gpio_dual_bank uut (
        .clk(clk), .rst_n(rst_n), .permit(permit), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq_prim(irq_prim), .irq_sec(irq_sec)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] swp(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr_raw(input logic pm, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        permit = pm; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; permit = 1'b1;
    endtask

    task automatic rd_raw(input logic pm, input logic [7:0] a, output logic [31:0] d);
        permit = pm; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        bus_sel = 1'b0; permit = 1'b1;
    endtask

    task automatic wr(input logic pm, input logic [7:0] a, input logic [31:0] v);
        wr_raw(pm, a, swp(v));
    endtask

    task automatic rd_chk(input string tag, input logic pm, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd_raw(pm, a, d);
        check(tag, swp(d), exp);
    endtask

    typedef struct packed {
        logic        is_rd;
        logic        pm;
        logic [7:0]  addr;
        logic [31:0] val;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 8'h3C, 32'h0000FFFF},
        '{1'b1, 1'b1, 8'h3C, 32'h0000FFFF},   // R4 owner readback
        '{1'b0, 1'b1, 8'h00, 32'hFFFFFFFF},
        '{1'b1, 1'b1, 8'h00, 32'h0000FFFF},   // R5 primary sees own half
        '{1'b0, 1'b1, 8'h20, 32'hFFFFFFFF},
        '{1'b1, 1'b1, 8'h20, 32'hFFFF0000},   // R5 secondary sees own half
        '{1'b0, 1'b1, 8'h04, 32'h000000F0},
        '{1'b1, 1'b1, 8'h04, 32'h000000F0},
        '{1'b0, 1'b1, 8'h24, 32'h00F00000},
        '{1'b1, 1'b1, 8'h24, 32'h00F00000},
        '{1'b0, 1'b1, 8'h1C, 32'h00300000},
        '{1'b1, 1'b1, 8'h1C, 32'h00300000},
        '{1'b0, 1'b0, 8'h3C, 32'h00000000},
        '{1'b1, 1'b1, 8'h3C, 32'h0000FFFF},   // R3 owner write blocked
        '{1'b1, 1'b0, 8'h24, 32'h00000000},   // R3 gated read is zero
        '{1'b0, 1'b0, 8'h04, 32'h0000000F},
        '{1'b1, 1'b0, 8'h04, 32'h0000000F},   // R3 primary always open
        '{1'b0, 1'b1, 8'h08, 32'hFFFFFFFF},
        '{1'b1, 1'b1, 8'h08, 32'h00000000},   // R10 input not writable
        '{1'b0, 1'b1, 8'h14, 32'h00000003},
        '{1'b1, 1'b1, 8'h14, 32'h00000003},
        '{1'b0, 1'b1, 8'h40, 32'hFFFFFFFF},
        '{1'b1, 1'b1, 8'h40, 32'h00000000},   // R10 out of range reads zero
        '{1'b1, 1'b1, 8'h00, 32'h0000FFFF},   // R10 out of range write ignored
        '{1'b0, 1'b1, 8'h05, 32'hFFFFFFFF},
        '{1'b1, 1'b1, 8'h04, 32'h0000000F}    // R10 misaligned write ignored
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 irqs", {30'h0, irq_prim, irq_sec}, 32'h0);
        rd_chk("R1 owner", 1'b1, 8'h3C, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].is_rd) begin
                @(negedge clk);
                rd_chk($sformatf("table step %0d", i), TBL[i].pm, TBL[i].addr, TBL[i].val);
            end else begin
                wr(TBL[i].pm, TBL[i].addr, TBL[i].val);
            end
        end

        // R4 pad steering
        @(negedge clk);
        check("R4 pad_oe split", pad_oe, 32'h0030000F);
        check("R4 pad_out split", pad_out, 32'hFFFFFFFF);
        wr(1'b1, 8'h3C, 32'h0010FFFF);
        check("R4 pad_oe moved line", pad_oe, 32'h0020000F);
        check("R4 pad_out moved line", pad_out, 32'hFFEFFFFF);
        wr(1'b1, 8'h3C, 32'h0000FFFF);

        // R9 / R8 flags and acknowledge
        check("R9 irq_prim pending", {31'h0, irq_prim}, 32'h1);
        wr(1'b1, 8'h0C, 32'h0000FFFF);
        wr(1'b1, 8'h10, 32'h00000001);
        rd_chk("R8 clear one bit", 1'b1, 8'h10, 32'h0010FFFE);
        wr(1'b1, 8'h10, 32'h00000000);
        rd_chk("R8 write zero no effect", 1'b1, 8'h10, 32'h0010FFFE);
        wr(1'b1, 8'h10, 32'hFFFFFFFF);
        rd_chk("R8 clear all", 1'b1, 8'h10, 32'h0);
        check("R9 irq_prim idle", {31'h0, irq_prim}, 32'h0);

        // R6 / R7 synchroniser and flag timing
        @(negedge clk) pad_in[0] = 1'b1;
        @(negedge clk);
        rd_chk("R6 input after one edge", 1'b1, 8'h08, 32'h0);
        @(negedge clk);
        rd_chk("R6 input after two edges", 1'b1, 8'h08, 32'h1);
        rd_chk("R7 flag not yet", 1'b1, 8'h10, 32'h0);
        @(negedge clk);
        rd_chk("R7 flag set", 1'b1, 8'h10, 32'h1);
        check("R9 irq_prim raised", {31'h0, irq_prim}, 32'h1);
        wr(1'b1, 8'h10, 32'h00000001);
        @(negedge clk);
        rd_chk("R8 live condition wins", 1'b1, 8'h10, 32'h1);

        @(negedge clk) pad_in[31] = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk("R6 input word", 1'b1, 8'h08, 32'h80000001);
        rd_chk("R6 primary mirror", 1'b1, 8'h18, 32'h00000001);
        rd_chk("R6 secondary mirror", 1'b1, 8'h38, 32'h80000000);

        // R7 / R9 secondary bank
        wr(1'b1, 8'h34, 32'h80000000);
        wr(1'b1, 8'h30, 32'hFFFFFFFF);
        @(negedge clk);
        rd_chk("R7 secondary flags", 1'b1, 8'h30, 32'h7FFF0000);
        check("R9 irq_sec idle", {31'h0, irq_sec}, 32'h0);
        wr(1'b1, 8'h2C, 32'h80000000);
        @(negedge clk);
        rd_chk("R7 polarity high", 1'b1, 8'h30, 32'hFFFF0000);
        check("R9 irq_sec raised", {31'h0, irq_sec}, 32'h1);
        rd_chk("R3 flag hidden", 1'b0, 8'h30, 32'h0);

        // R2 lane order
        wr_raw(1'b1, 8'h14, 32'h01000000);
        check("R2 lane of line 0", {31'h0, irq_prim}, 32'h1);
        wr_raw(1'b1, 8'h14, 32'h00000001);
        check("R2 lane of line 24", {31'h0, irq_prim}, 32'h0);
        rd_raw(1'b1, 8'h14, d);
        check("R2 raw readback", d, 32'h00000001);

        // R1 reset mid-run
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pad_oe again", pad_oe, 32'h0);
        check("R1 pad_out again", pad_out, 32'h0);
        check("R1 irqs again", {30'h0, irq_prim, irq_sec}, 32'h0);
        rd_chk("R1 owner again", 1'b1, 8'h3C, 32'h0);
        rd_chk("R1 secondary output", 1'b1, 8'h20, 32'h0);
        rd_chk("R7 unowned primary flags", 1'b1, 8'h10, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule